// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs complete register-style transfers against an I2C device that keeps an internal address pointer. It sits above a separate bit engine, which performs the actual START, STOP, byte-write and byte-read bus actions. The sequencer only decides which action comes next, based on the acknowledge bits it gets back. A request names a 7-bit device address, a register address of zero up to `ADDR_BYTES` bytes, a byte count and one of three operations. The operation codes are probe = 0, read = 1 and write = 2.

Write payload comes in on a valid/ready byte stream, and read payload goes out on another. A byte moves on a rising edge where valid and ready are both high. The sequencer holds `rd_valid` and `rd_data` unchanged until the consumer takes the byte, and it fetches no further read byte from the bus while one is waiting. It raises `wr_ready` only while it needs the next payload byte of a write, so a producer may keep `wr_valid` high at any time. The bit engine uses the same rule on its command channel. Each accepted command is answered by exactly one response pulse, and only one command is in flight at a time.

When the transfer ends, `done` pulses for one cycle. At the same time `status` gives the result (0 ok or device present, 1 no response, 2 register address refused), and `fail_count` gives the number of refused payload bytes in a write. The configuration inputs `cfg_rep_start` and `cfg_ovf_mask` are sampled when a request is accepted.

Top module: `i2c_reg_seq`

## Requirements
- R1: A probe issues START, then the byte {chip,0}, then STOP. It ends with status 0 when that byte was acknowledged and status 1 when it was refused.
- R2: In a write, and in a read with a non-zero address length, a refused {chip,0} byte is followed by STOP and status 1. No address or payload bytes are sent and no write-stream byte is taken.
- R3: Register address bytes go out most significant byte first. Exactly `req_alen` of them are sent, and `req_alen` never exceeds `ADDR_BYTES`.
- R4: A refused register address byte ends the transfer at once with status 2. No STOP is issued and nothing more is sent.
- R5: In a write, a refused payload byte does not stop the transfer. Every payload byte is sent, then STOP, and the transfer ends with status 0 and `fail_count` equal to the number of refused payload bytes. `fail_count` is 0 for any other status.
- R6: A read with a non-zero address length follows its address bytes with STOP then START when `cfg_rep_start` is 0, and with START alone when it is 1.
- R7: A read with address length 0 issues START and then {chip,1} directly.
- R8: Read bytes are requested with acknowledge level 0, except the last one, which gets level 1 (`bus_cmd_nack` high). STOP follows the last byte. The acknowledge of the {chip,1} byte is not examined. Bytes reach `rd_data` in bus order.
- R9: The chip field of every address byte sent is chip | ((address >> 8*alen) & `cfg_ovf_mask`), so address bits above the sent length select among devices.
- R10: `req_ready` is high only while the block is idle. `done` is a single-cycle pulse, and `status` takes only the values 0, 1 and 2.
- R11: Bus command op (START 0, STOP 1, WRITE 2, READ 3), data and acknowledge level stay stable while `bus_cmd_valid` is high without `bus_cmd_ready`. No new command starts before the response to the previous one.
- R12: `rd_data` stays stable while `rd_valid` waits for `rd_ready`. Write-stream bytes are taken only in the payload phase of a write, one per payload byte.
- R13: After reset the block is idle: `req_ready` is 1, and `done`, `bus_cmd_valid`, `rd_valid` and `wr_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 0 probe, 1 read, 2 write |
| req_chip | input | 7 | Device address |
| req_addr | input | 8*ADDR_BYTES | Register address, including overflow bits |
| req_alen | input | clog2(ADDR_BYTES+1) | Register address length in bytes |
| req_len | input | LEN_W | Payload byte count |
| cfg_rep_start | input | 1 | 1: repeated START turnaround; 0: STOP then START |
| cfg_ovf_mask | input | 7 | Mask of address overflow bits folded into the chip field |
| wr_valid | input | 1 | Write payload byte present |
| wr_ready | output | 1 | Sequencer takes a write payload byte |
| wr_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| bus_cmd_valid | output | 1 | Command to the bit engine present |
| bus_cmd_ready | input | 1 | Bit engine accepts the command |
| bus_cmd_op | output | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| bus_cmd_data | output | 8 | Byte to write |
| bus_cmd_nack | output | 1 | Acknowledge level to drive after a read byte |
| bus_rsp_valid | input | 1 | Command finished |
| bus_rsp_nack | input | 1 | Written byte was refused |
| bus_rsp_data | input | 8 | Byte read |
| done | output | 1 | Transfer finished, one-cycle pulse |
| status | output | 2 | 0 ok, 1 no response, 2 address refused |
| fail_count | output | LEN_W | Refused payload bytes in the last write |

## Verification
The assertions take three things for granted. An accepted request never asks for more address bytes than `ADDR_BYTES`. The bit engine holds `bus_cmd_ready` only for a command that is valid. It answers each accepted command with exactly one `bus_rsp_valid` pulse, and never before the command was taken. The stimulus keeps every table entry within the address length limit. The bit-engine model takes a command, waits one cycle and then responds once. It stalls ready on every third command, which exercises the hold rule. The write producer offers data continuously, with gaps, and the read consumer drops ready periodically, so both stream rules see back-pressure.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } req_op_e;

  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_STOP  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_NORESP  = 2'd1,
    RES_ADDRNAK = 2'd2
  } result_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_CHIPW,
    S_ADDR,
    S_TSTOP,
    S_RSTART,
    S_CHIPR,
    S_WDATA,
    S_RDATA,
    S_STOP,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr #(
  parameter int ADDR_BYTES = 4,
  parameter int AW         = 8 * ADDR_BYTES,
  parameter int ALW        = $clog2(ADDR_BYTES + 1)
) (
  input  logic [AW-1:0]  addr,
  input  logic [ALW-1:0] alen,
  input  logic [ALW-1:0] idx,
  input  logic [6:0]     chip,
  input  logic [6:0]     mask,
  output logic [6:0]     chip_eff,
  output logic [7:0]     byte_out
);

  // ovf[k]: low bits of the address above k bytes; nothing above all bytes
  logic [6:0] ovf  [ADDR_BYTES+1];
  logic [7:0] lane [ADDR_BYTES];

  for (genvar k = 0; k <= ADDR_BYTES; k++) begin : g_lane
    if (k < ADDR_BYTES) begin : g_in
      assign ovf[k]  = addr[8*k +: 7];
      assign lane[k] = addr[8*k +: 8];
    end else begin : g_top
      assign ovf[k] = '0;
    end
  end

  always_comb begin
    chip_eff = chip;
    for (int k = 0; k <= ADDR_BYTES; k++) begin
      if (alen == ALW'(k)) chip_eff = chip | (ovf[k] & mask);
    end
  end

  always_comb begin
    byte_out = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (idx == ALW'(k)) byte_out = lane[k];
    end
  end

endmodule

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [1:0] issue_op,
  input  logic [7:0] issue_data,
  input  logic       issue_nack,
  output logic       bus_cmd_valid,
  input  logic       bus_cmd_ready,
  output logic [1:0] bus_cmd_op,
  output logic [7:0] bus_cmd_data,
  output logic       bus_cmd_nack,
  input  logic       bus_rsp_valid,
  input  logic       bus_rsp_nack,
  input  logic [7:0] bus_rsp_data,
  output logic       fin,
  output logic       fin_nack,
  output logic [7:0] fin_data
);

  logic       cmd_v;
  logic       wait_q;
  logic [1:0] op_q;
  logic [7:0] data_q;
  logic       nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v  <= 1'b0;
      wait_q <= 1'b0;
      op_q   <= BUS_START;
      data_q <= '0;
      nack_q <= 1'b0;
    end else begin
      if (issue) begin
        cmd_v  <= 1'b1;
        op_q   <= issue_op;
        data_q <= issue_data;
        nack_q <= issue_nack;
      end else if (cmd_v && bus_cmd_ready) begin
        cmd_v  <= 1'b0;
        wait_q <= 1'b1;
      end
      if (wait_q && bus_rsp_valid) wait_q <= 1'b0;
    end
  end

  assign bus_cmd_valid = cmd_v;
  assign bus_cmd_op    = op_q;
  assign bus_cmd_data  = data_q;
  assign bus_cmd_nack  = nack_q;
  assign fin           = wait_q && bus_rsp_valid;
  assign fin_nack      = bus_rsp_nack;
  assign fin_data      = bus_rsp_data;

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && !bus_cmd_ready |=> bus_cmd_valid && $stable(bus_cmd_op)
      && $stable(bus_cmd_data) && $stable(bus_cmd_nack)); // R11
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !cmd_v && !wait_q); // R11

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int AW         = 8 * ADDR_BYTES,
  parameter int ALW        = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [6:0]       req_chip,
  input  logic [AW-1:0]    req_addr,
  input  logic [ALW-1:0]   req_alen,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cfg_rep_start,
  input  logic [6:0]       cfg_ovf_mask,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             issue,
  output logic [1:0]       issue_op,
  output logic [7:0]       issue_data,
  output logic             issue_nack,
  input  logic             fin,
  input  logic             fin_nack,
  input  logic [7:0]       fin_data,
  output logic             done,
  output logic [1:0]       status,
  output logic [LEN_W-1:0] fail_count
);

  seq_state_e       st;
  logic             sent;
  logic [1:0]       l_op;
  logic [6:0]       l_chip;
  logic [AW-1:0]    l_addr;
  logic [ALW-1:0]   l_alen;
  logic             l_rep;
  logic [6:0]       l_mask;
  logic [LEN_W-1:0] cnt;
  logic [ALW-1:0]   idx;
  logic             rd_full;
  logic [7:0]       rd_buf;
  logic [1:0]       res_q;
  logic [LEN_W-1:0] fail_q;
  logic [6:0]       chip_eff;
  logic [7:0]       addr_byte;
  logic             need_cmd;

  i2c_seq_addr #(.ADDR_BYTES(ADDR_BYTES), .AW(AW), .ALW(ALW)) u_addr (
    .addr    (l_addr),
    .alen    (l_alen),
    .idx     (idx),
    .chip    (l_chip),
    .mask    (l_mask),
    .chip_eff(chip_eff),
    .byte_out(addr_byte)
  );

  assign need_cmd = (st == S_START) || (st == S_CHIPW) || (st == S_ADDR)
                 || (st == S_TSTOP) || (st == S_RSTART) || (st == S_CHIPR)
                 || (st == S_STOP);

  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_WDATA) && !sent;
  assign rd_valid  = rd_full;
  assign rd_data   = rd_buf;
  assign done      = (st == S_DONE);
  assign status    = res_q;
  assign fail_count = fail_q;

  assign issue = !sent && (need_cmd
               || ((st == S_WDATA) && wr_valid)
               || ((st == S_RDATA) && !rd_full));

  always_comb begin
    issue_op   = BUS_START;
    issue_data = '0;
    issue_nack = 1'b0;
    unique case (st)
      S_START, S_RSTART: issue_op = BUS_START;
      S_TSTOP, S_STOP:   issue_op = BUS_STOP;
      S_CHIPW: begin
        issue_op   = BUS_WRITE;
        issue_data = {chip_eff, 1'b0};
      end
      S_CHIPR: begin
        issue_op   = BUS_WRITE;
        issue_data = {chip_eff, 1'b1};
      end
      S_ADDR: begin
        issue_op   = BUS_WRITE;
        issue_data = addr_byte;
      end
      S_WDATA: begin
        issue_op   = BUS_WRITE;
        issue_data = wr_data;
      end
      S_RDATA: begin
        issue_op   = BUS_READ;
        issue_nack = (cnt == LEN_W'(1));
      end
      default: issue_op = BUS_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sent    <= 1'b0;
      l_op    <= OP_PROBE;
      l_chip  <= '0;
      l_addr  <= '0;
      l_alen  <= '0;
      l_rep   <= 1'b0;
      l_mask  <= '0;
      cnt     <= '0;
      idx     <= '0;
      rd_full <= 1'b0;
      rd_buf  <= '0;
      res_q   <= RES_OK;
      fail_q  <= '0;
    end else begin
      if (issue) sent <= 1'b1;
      if (fin)   sent <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            l_op   <= req_op;
            l_chip <= req_chip;
            l_addr <= req_addr;
            l_alen <= req_alen;
            l_rep  <= cfg_rep_start;
            l_mask <= cfg_ovf_mask;
            cnt    <= req_len;
            res_q  <= RES_OK;
            fail_q <= '0;
            sent   <= 1'b0;
            st     <= S_START;
          end
        end
        S_START: if (fin) begin
          if (l_op == OP_READ && l_alen == '0) st <= S_CHIPR;
          else                                 st <= S_CHIPW;
        end
        S_CHIPW: if (fin) begin
          if (fin_nack) begin
            res_q <= RES_NORESP;
            st    <= S_STOP;
          end else if (l_op == OP_PROBE) begin
            st <= S_STOP;
          end else if (l_alen != '0) begin
            idx <= l_alen - ALW'(1);
            st  <= S_ADDR;
          end else begin
            st <= (cnt != '0) ? S_WDATA : S_STOP;
          end
        end
        S_ADDR: if (fin) begin
          if (fin_nack) begin
            res_q <= RES_ADDRNAK;
            st    <= S_DONE;
          end else if (idx != '0) begin
            idx <= idx - ALW'(1);
          end else if (l_op == OP_WRITE) begin
            st <= (cnt != '0) ? S_WDATA : S_STOP;
          end else begin
            st <= l_rep ? S_RSTART : S_TSTOP;
          end
        end
        S_TSTOP:  if (fin) st <= S_RSTART;
        S_RSTART: if (fin) st <= S_CHIPR;
        S_CHIPR:  if (fin) st <= (cnt != '0) ? S_RDATA : S_STOP;
        S_WDATA: if (fin) begin
          if (fin_nack) fail_q <= fail_q + LEN_W'(1);
          cnt <= cnt - LEN_W'(1);
          if (cnt == LEN_W'(1)) st <= S_STOP;
        end
        S_RDATA: begin
          if (fin) begin
            rd_full <= 1'b1;
            rd_buf  <= fin_data;
            cnt     <= cnt - LEN_W'(1);
          end else if (rd_full && rd_ready) begin
            rd_full <= 1'b0;
            if (cnt == '0) st <= S_STOP;
          end
        end
        S_STOP: if (fin) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 2'd3); // R10
  AST_ALEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> req_alen <= ALW'(ADDR_BYTES)); // R3
  AST_FAIL_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done && status != RES_OK |-> fail_count == '0); // R5
  AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R12
  AST_WR_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> l_op == OP_WRITE && !req_ready); // R12

endmodule

// File: rtl/i2c_reg_seq.sv
module i2c_reg_seq #(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 8,
  localparam int AW        = 8 * ADDR_BYTES,
  localparam int ALW       = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [6:0]       req_chip,
  input  logic [AW-1:0]    req_addr,
  input  logic [ALW-1:0]   req_alen,
  input  logic [LEN_W-1:0] req_len,
  input  logic             cfg_rep_start,
  input  logic [6:0]       cfg_ovf_mask,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             bus_cmd_valid,
  input  logic             bus_cmd_ready,
  output logic [1:0]       bus_cmd_op,
  output logic [7:0]       bus_cmd_data,
  output logic             bus_cmd_nack,
  input  logic             bus_rsp_valid,
  input  logic             bus_rsp_nack,
  input  logic [7:0]       bus_rsp_data,
  output logic             done,
  output logic [1:0]       status,
  output logic [LEN_W-1:0] fail_count
);

  logic       issue;
  logic [1:0] issue_op;
  logic [7:0] issue_data;
  logic       issue_nack;
  logic       fin;
  logic       fin_nack;
  logic [7:0] fin_data;

  i2c_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .AW(AW), .ALW(ALW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_chip     (req_chip),
    .req_addr     (req_addr),
    .req_alen     (req_alen),
    .req_len      (req_len),
    .cfg_rep_start(cfg_rep_start),
    .cfg_ovf_mask (cfg_ovf_mask),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .issue        (issue),
    .issue_op     (issue_op),
    .issue_data   (issue_data),
    .issue_nack   (issue_nack),
    .fin          (fin),
    .fin_nack     (fin_nack),
    .fin_data     (fin_data),
    .done         (done),
    .status       (status),
    .fail_count   (fail_count)
  );

  i2c_seq_cmd u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue),
    .issue_op     (issue_op),
    .issue_data   (issue_data),
    .issue_nack   (issue_nack),
    .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd_ready(bus_cmd_ready),
    .bus_cmd_op   (bus_cmd_op),
    .bus_cmd_data (bus_cmd_data),
    .bus_cmd_nack (bus_cmd_nack),
    .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_nack (bus_rsp_nack),
    .bus_rsp_data (bus_rsp_data),
    .fin          (fin),
    .fin_nack     (fin_nack),
    .fin_data     (fin_data)
  );

endmodule

// File: tb/i2c_reg_seq_test.sv
`timescale 1ns/1ps
module i2c_reg_seq_test;

  localparam int NV = 16;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  chip;
    logic [31:0] addr;
    logic [2:0]  alen;
    logic [7:0]  len;
    logic        rep;
    logic [6:0]  mask;
    logic [15:0] nak;
    logic [1:0]  est;
    logic [7:0]  efail;
  } vec_t;

  // op: 0 probe, 1 read, 2 write; nak bit n refuses the n-th written byte
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0}, // R1 present
    '{2'd0, 7'h51, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 16'h0001, 2'd1, 8'd0}, // R1 absent
    '{2'd2, 7'h50, 32'h1234,     3'd2, 8'd3, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0}, // R3 R5
    '{2'd2, 7'h52, 32'h77,       3'd1, 8'd2, 1'b0, 7'h00, 16'h0001, 2'd1, 8'd0}, // R2
    '{2'd2, 7'h50, 32'hABCD,     3'd2, 8'd2, 1'b0, 7'h00, 16'h0004, 2'd2, 8'd0}, // R4
    '{2'd2, 7'h50, 32'h10,       3'd1, 8'd4, 1'b0, 7'h00, 16'h0014, 2'd0, 8'd2}, // R5
    '{2'd1, 7'h50, 32'h20,       3'd1, 8'd3, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0}, // R6 R8
    '{2'd1, 7'h50, 32'h0102,     3'd2, 8'd2, 1'b1, 7'h00, 16'h0000, 2'd0, 8'd0}, // R6
    '{2'd1, 7'h48, 32'h0,        3'd0, 8'd2, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0}, // R7
    '{2'd1, 7'h50, 32'h3A5,      3'd1, 8'd1, 1'b0, 7'h07, 16'h0000, 2'd0, 8'd0}, // R9
    '{2'd1, 7'h50, 32'h0,        3'd0, 8'd2, 1'b0, 7'h00, 16'h0001, 2'd0, 8'd0}, // R8
    '{2'd2, 7'h50, 32'hDEADBEEF, 3'd4, 8'd1, 1'b0, 7'h7F, 16'h0000, 2'd0, 8'd0}, // R3 R9
    '{2'd1, 7'h50, 32'h5,        3'd1, 8'd2, 1'b0, 7'h00, 16'h0001, 2'd1, 8'd0}, // R2
    '{2'd2, 7'h22, 32'h0,        3'd0, 8'd0, 1'b0, 7'h00, 16'h0000, 2'd0, 8'd0}, // R5
    '{2'd2, 7'h50, 32'h240,      3'd1, 8'd1, 1'b0, 7'h03, 16'h0004, 2'd0, 8'd1}, // R9 R5
    '{2'd1, 7'h50, 32'h0A0B,     3'd2, 8'd2, 1'b1, 7'h00, 16'h0004, 2'd2, 8'd0}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [6:0]  req_chip = '0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_alen = '0;
  logic [7:0]  req_len = '0;
  logic        cfg_rep_start = 1'b0;
  logic [6:0]  cfg_ovf_mask = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        bus_cmd_valid;
  logic        bus_cmd_ready = 1'b0;
  logic [1:0]  bus_cmd_op;
  logic [7:0]  bus_cmd_data;
  logic        bus_cmd_nack;
  logic        bus_rsp_valid = 1'b0;
  logic        bus_rsp_nack = 1'b0;
  logic [7:0]  bus_rsp_data = '0;
  logic        done;
  logic [1:0]  status;
  logic [7:0]  fail_count;

  i2c_reg_seq #(.ADDR_BYTES(4), .LEN_W(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_chip(req_chip), .req_addr(req_addr), .req_alen(req_alen),
    .req_len(req_len), .cfg_rep_start(cfg_rep_start), .cfg_ovf_mask(cfg_ovf_mask),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd_ready(bus_cmd_ready),
    .bus_cmd_op(bus_cmd_op), .bus_cmd_data(bus_cmd_data), .bus_cmd_nack(bus_cmd_nack),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_nack(bus_rsp_nack), .bus_rsp_data(bus_rsp_data),
    .done(done), .status(status), .fail_count(fail_count)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bus trace entries: {op, data, ack level (reads only)}
  logic [10:0] log_q [64];
  int          log_n = 0;
  logic [10:0] exp_q [64];
  int          exp_n = 0;
  logic [7:0]  rd_log [64];
  int          rd_n = 0;
  int          widx = 0;
  int          wcount = 0;
  int          rcount = 0;
  logic [15:0] cur_nak = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // bit-engine model: accept, wait a cycle, respond once; stall every third command
  initial begin
    int phase = 0;
    int ncmd = 0;
    bit stall = 1'b0;
    logic [1:0] cop = '0;
    forever begin
      @(negedge clk);
      bus_rsp_valid = 1'b0;
      case (phase)
        0: if (bus_cmd_valid && rst_n) begin
          if (stall) stall = 1'b0;
          else begin
            bus_cmd_ready = 1'b1;
            cop = bus_cmd_op;
            if (log_n < 64) begin
              log_q[log_n] = {bus_cmd_op, bus_cmd_data,
                              (bus_cmd_op == 2'd3) ? bus_cmd_nack : 1'b0};
              log_n++;
            end
            stall = (ncmd % 3) == 2;
            ncmd++;
            phase = 1;
          end
        end
        1: begin
          bus_cmd_ready = 1'b0;
          phase = 2;
        end
        default: begin
          bus_rsp_valid = 1'b1;
          bus_rsp_nack  = 1'b0;
          if (cop == 2'd2) begin
            bus_rsp_nack = (wcount < 16) ? cur_nak[wcount] : 1'b0;
            wcount++;
          end
          if (cop == 2'd3) begin
            bus_rsp_data = 8'hA0 + 8'(rcount);
            rcount++;
          end
          phase = 0;
        end
      endcase
    end
  end

  // write producer: offers bytes 0x30+n with gaps
  initial forever begin
    @(negedge clk);
    wr_valid = (cyc % 3) != 0;
    wr_data  = 8'h30 + 8'(widx);
    if (wr_valid && wr_ready) widx++;
  end

  // read consumer: drops ready one cycle in four
  initial forever begin
    bit rr;
    @(negedge clk);
    rr = (cyc % 4) != 1;
    if (rd_valid && rr && rd_n < 64) begin
      rd_log[rd_n] = rd_data;
      rd_n++;
    end
    rd_ready = rr;
  end

  function automatic void push(input logic [1:0] op, input logic [7:0] d, input logic a);
    exp_q[exp_n] = {op, d, a};
    exp_n++;
  endfunction

  int exp_wr = 0;
  int exp_rd = 0;

  task automatic build_exp(input vec_t v);
    int wi = 0;
    logic [63:0] a64;
    logic [6:0] ce;
    bit nk;
    exp_n = 0; exp_wr = 0; exp_rd = 0;
    a64 = {32'd0, v.addr} >> (8 * v.alen);
    ce  = v.chip | (a64[6:0] & v.mask);
    push(2'd0, 8'h00, 1'b0);
    if (v.op == 2'd0) begin
      push(2'd2, {ce, 1'b0}, 1'b0);
      push(2'd1, 8'h00, 1'b0);
      return;
    end
    if (!(v.op == 2'd1 && v.alen == 0)) begin
      push(2'd2, {ce, 1'b0}, 1'b0);
      nk = v.nak[wi]; wi++;
      if (nk) begin
        push(2'd1, 8'h00, 1'b0);
        return;
      end
      for (int k = int'(v.alen) - 1; k >= 0; k--) begin
        push(2'd2, v.addr[8*k +: 8], 1'b0);
        nk = v.nak[wi]; wi++;
        if (nk) return;
      end
    end
    if (v.op == 2'd2) begin
      for (int n = 0; n < int'(v.len); n++) push(2'd2, 8'h30 + 8'(n), 1'b0);
      exp_wr = v.len;
      push(2'd1, 8'h00, 1'b0);
      return;
    end
    if (v.alen != 0) begin
      if (!v.rep) push(2'd1, 8'h00, 1'b0);
      push(2'd0, 8'h00, 1'b0);
    end
    push(2'd2, {ce, 1'b1}, 1'b0);
    for (int n = 0; n < int'(v.len); n++) push(2'd3, 8'h00, (n == int'(v.len) - 1));
    exp_rd = v.len;
    push(2'd1, 8'h00, 1'b0);
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 1:   return "R1";
      2:      return "R3";
      3, 12:  return "R2";
      4, 15:  return "R4";
      5, 13:  return "R5";
      6, 7:   return "R6";
      8:      return "R7";
      10:     return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    string tg = tag_of(i);
    int t = 0;
    int bad = -1;
    logic [1:0] got_st;
    logic [7:0] got_fail;
    build_exp(v);
    @(negedge clk);
    log_n = 0; rd_n = 0; widx = 0; wcount = 0; rcount = 0;
    cur_nak = v.nak;
    req_op = v.op; req_chip = v.chip; req_addr = v.addr; req_alen = v.alen;
    req_len = v.len; cfg_rep_start = v.rep; cfg_ovf_mask = v.mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", $sformatf("vec%0d busy req_ready", i), req_ready, 0);
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, tg, $sformatf("vec%0d completion", i), done, 1);
    got_st = status; got_fail = fail_count;
    @(negedge clk);
    chk(done == 1'b0, "R10", $sformatf("vec%0d done width", i), done, 0);
    chk(got_st == v.est, tg, $sformatf("vec%0d status", i), got_st, v.est);
    chk(got_fail == v.efail, "R5", $sformatf("vec%0d fail_count", i), got_fail, v.efail);
    chk(log_n == exp_n, tg, $sformatf("vec%0d bus command count", i), log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++)
      if (bad < 0 && log_q[k] != exp_q[k]) bad = k;
    chk(bad < 0, tg, $sformatf("vec%0d bus command #%0d {op,data,ack}", i, bad),
        (bad < 0) ? 0 : log_q[bad], (bad < 0) ? 0 : exp_q[bad]);
    chk(widx == exp_wr, "R12", $sformatf("vec%0d write bytes taken", i), widx, exp_wr);
    chk(rd_n == exp_rd, "R8", $sformatf("vec%0d read bytes delivered", i), rd_n, exp_rd);
    for (int k = 0; k < rd_n && k < exp_rd; k++)
      chk(rd_log[k] == 8'hA0 + 8'(k), "R8", $sformatf("vec%0d read byte %0d", i, k),
          rd_log[k], 8'hA0 + 8'(k));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(req_ready == 1'b1, "R13", "req_ready after reset", req_ready, 1);
    chk(done == 1'b0, "R13", "done after reset", done, 0);
    chk(bus_cmd_valid == 1'b0, "R13", "bus_cmd_valid after reset", bus_cmd_valid, 0);
    chk(rd_valid == 1'b0, "R13", "rd_valid after reset", rd_valid, 0);
    chk(wr_ready == 1'b0, "R13", "wr_ready after reset", wr_ready, 0);
    // R11 is exercised by the engine stalls inside every vector
    for (int i = 0; i < NV; i++) run_vec(i);
    // idle after a run: no stream activity leaks (R12, R10)
    repeat (5) @(negedge clk);
    chk(wr_ready == 1'b0, "R12", "wr_ready when idle", wr_ready, 0);
    chk(req_ready == 1'b1, "R10", "req_ready when idle", req_ready, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

endmodule